// File: doc/BRIEF.md
# Two-Wire Bus Slave Front End with Wake Refusal

This block is the bus-facing half of a peripheral that answers a host over a two-wire serial bus (clock and open-drain data). It oversamples both bus lines with the core clock through synchronizers, recognises start and stop conditions, and compares the first byte of each transfer with a fixed 7-bit device address. On a match it acknowledges and then either hands received bytes to the core through a write-data port with a one-cycle strobe, or takes bytes from a read-data port and shifts them onto the bus most significant bit first. The block only answers the host. It never drives the clock line and never begins a transfer on its own. The clock line is only sampled, so bus speeds up to 400 kHz are handled with plenty of margin at typical core clocks.

The block also sits next to a power controller. Every start condition produces a one-cycle wake request toward that controller. When the controller reports that the device has just left its halt state, the block refuses the next address byte with a NACK, even if the address matches. This lets the host repeat the transfer once the device is fully awake. After that single refusal, addressing works normally again.

Top module: `twowire_wake_slave`

## Requirements
- R1: The device address is the 7-bit value 0x51, compared against bits 7:1 of the first byte after a start, so the byte 0xA2 (write) or 0xA3 (read) matches. A matching address byte is acknowledged by pulling SDA low during the ninth clock.
- R2: A non-matching address byte is not acknowledged. The block then leaves SDA released and produces no write or read strobe until the next start or stop condition.
- R3: In a write transfer (address bit 0 = 0), each received data byte appears on wr_data with a one-cycle wr_strobe and is acknowledged. Bits are received MSB first.
- R4: In a read transfer (address bit 0 = 1), rd_data is taken with a one-cycle rd_strobe when the address acknowledge clock ends. It is then driven onto SDA MSB first.
- R5: During a read, a host ACK (SDA low on the ninth clock) makes the block fetch and send the next byte with another rd_strobe. A host NACK makes it release SDA and stay idle until the next start or stop.
- R6: After a one-cycle pulse on wake_pulse, the next address byte is answered with a NACK even if it matches. The refusal is consumed by that one byte, so a repeated matching address is acknowledged.
- R7: Each start condition (SDA falling while SCL is high) produces exactly one one-cycle pulse on wake_req.
- R8: A repeated start in the middle of a transfer abandons the transfer and begins a new address phase.
- R9: A stop condition (SDA rising while SCL is high) returns the block to idle. Clock pulses that follow it, without a new start, cause no acknowledge and no strobe.
- R10: While rst_n is low and directly after reset, sda_pull, wr_strobe, rd_strobe and wake_req are all 0.
- R11: sda_pull only begins pulling SDA low while the synchronized SCL is low. The block has no output on the clock line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | 1 pulls the open-drain data line low, 0 releases it |
| wake_pulse | input | 1 | One-cycle pulse from the power controller on leaving halt |
| wake_req | output | 1 | One-cycle wake request on each start condition |
| wr_data | output | 8 | Last byte received in a write transfer |
| wr_strobe | output | 1 | One-cycle strobe marking a new wr_data byte |
| rd_data | input | 8 | Byte to send in a read transfer, sampled at rd_strobe |
| rd_strobe | output | 1 | One-cycle strobe marking the cycle rd_data is taken |

## Verification
On every cycle, the assertions check these properties: the data line is never pulled while the transfer is being ignored, a pull only starts while the clock is low, wake requests last a single cycle, the two byte strobes never coincide, and a refused post-wake address byte leaves the line released and the refusal consumed. Only the bench scenarios can show the values that cross the bus. They check that the right address bytes are acknowledged and the wrong ones are not, that written bytes arrive intact and in order, and that read bytes leave MSB first in a chained sequence. They also cover the recovery paths: the host retry after a wake refusal, repeated starts, and stops.

// File: rtl/twowire_slave_pkg.sv
// Shared types for the two-wire slave front end.
// Assumes: used by every module of the slave, compiled first.
package twowire_slave_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_DEC,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_DEC,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_RD_NEXT,
        ST_IGNORE
    } slv_state_t;
endpackage

// File: rtl/bus_sync.sv
// Multi-stage synchronizer for the bus lines. Each bit gets its own
// flop chain, and every stage resets to the idle level of the bus (high).
// Assumes: inputs are asynchronous to clk. All bits use the same depth,
// so their relative order is kept.
module bus_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            // shift the pad level through the flop chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], async_in[b]};
            end
            assign sync_out[b] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/bus_cond.sv
// Edge and bus-condition detector on the synchronized lines. It flags
// SCL rising and falling edges, and start/stop conditions (an SDA edge
// while SCL is high on two samples running).
// Assumes: scl_s and sda_s come from the same synchronizer depth.
module bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    // keep the previous sample of both lines
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // decode edges and conditions from current and previous samples
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/slave_fsm.sv
// Byte-level slave engine. It matches the address, acknowledges bytes,
// shifts write data in and read data out MSB first, and refuses the
// first address byte after a wake from halt.
// Assumes: the core clock is many times the bus bit rate, and the host
// changes SDA only while SCL is low (except for start/stop).
module slave_fsm
    import twowire_slave_pkg::*;
#(
    parameter int         BYTE_W   = 8,
    parameter int         ADDR_W   = 7,
    parameter logic [6:0] DEV_ADDR = 7'h51
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              wake_pulse,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_pull,
    output logic              wake_req,
    output logic [BYTE_W-1:0] wr_data,
    output logic              wr_strobe,
    output logic              rd_strobe
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(BYTE_W);

    slv_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic              dir_rd;
    logic              wake_flag;
    logic              addr_match;

    // compare the address field of the received byte
    always_comb addr_match = (shreg[BYTE_W-1 -: ADDR_W] == DEV_ADDR[ADDR_W-1:0]);

    // main transfer sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            shreg     <= '0;
            dir_rd    <= 1'b0;
            wake_flag <= 1'b0;
            sda_pull  <= 1'b0;
            wake_req  <= 1'b0;
            wr_data   <= '0;
            wr_strobe <= 1'b0;
            rd_strobe <= 1'b0;
        end else begin
            wake_req  <= 1'b0;
            wr_strobe <= 1'b0;
            rd_strobe <= 1'b0;
            if (start_det) begin
                state    <= ST_ADDR;
                cnt      <= '0;
                sda_pull <= 1'b0;
                wake_req <= 1'b1;
            end else if (stop_det) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_WR_DATA: begin
                        if (scl_rise) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_s};
                            if (cnt == LAST_BIT)
                                state <= (state == ST_ADDR) ? ST_ADDR_DEC : ST_WR_DEC;
                            else
                                cnt <= cnt + 1'b1;
                        end
                    end
                    ST_ADDR_DEC: begin
                        if (scl_fall) begin
                            dir_rd <= shreg[0];
                            if (wake_flag) begin
                                wake_flag <= 1'b0;
                                state     <= ST_IGNORE;
                            end else if (addr_match) begin
                                sda_pull <= 1'b1;
                                state    <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_RD_NEXT: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (dir_rd) begin
                                shreg     <= rd_data;
                                rd_strobe <= 1'b1;
                                sda_pull  <= ~rd_data[BYTE_W-1];
                                state     <= ST_RD_DATA;
                            end else begin
                                sda_pull <= 1'b0;
                                state    <= ST_WR_DATA;
                            end
                        end
                    end
                    ST_WR_DEC: begin
                        if (scl_fall) begin
                            wr_data   <= shreg;
                            wr_strobe <= 1'b1;
                            sda_pull  <= 1'b1;
                            state     <= ST_WR_ACK;
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            sda_pull <= 1'b0;
                            cnt      <= '0;
                            state    <= ST_WR_DATA;
                        end
                    end
                    ST_RD_DATA: begin
                        if (scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (cnt == ALL_BITS) begin
                                sda_pull <= 1'b0;
                                state    <= ST_RD_ACK;
                            end else begin
                                shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_pull <= ~shreg[BYTE_W-2];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise)
                            state <= sda_s ? ST_IGNORE : ST_RD_NEXT;
                    end
                    default: ;
                endcase
            end
            if (wake_pulse) wake_flag <= 1'b1;
        end
    end

    // R2
    ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !sda_pull);

    // R11
    pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_s);

    // R7
    wake_req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |=> !wake_req);

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_strobe, rd_strobe}));

    // R6
    wake_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_DEC && scl_fall && wake_flag && !start_det && !stop_det && !wake_pulse)
        |=> (!sda_pull && !wake_flag));
endmodule

// File: rtl/twowire_wake_slave.sv
// Top of the two-wire bus slave front end. It chains the synchronizers,
// the condition detector and the byte engine.
// Assumes: SDA is open-drain outside this block (sda_pull=1 drives it
// low), and SCL is only ever sampled.
module twowire_wake_slave #(
    parameter int         SYNC_STAGES = 2,
    parameter int         BYTE_W      = 8,
    parameter logic [6:0] DEV_ADDR    = 7'h51
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    input  logic              wake_pulse,
    output logic              wake_req,
    output logic [BYTE_W-1:0] wr_data,
    output logic              wr_strobe,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              rd_strobe
);
    logic [1:0] lines_s;
    logic scl_rise, scl_fall, start_det, stop_det;

    bus_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n),
        .async_in({scl_in, sda_in}), .sync_out(lines_s)
    );

    bus_cond cond_i (
        .clk(clk), .rst_n(rst_n),
        .scl_s(lines_s[1]), .sda_s(lines_s[0]),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    slave_fsm #(.BYTE_W(BYTE_W), .ADDR_W(7), .DEV_ADDR(DEV_ADDR)) fsm_i (
        .clk(clk), .rst_n(rst_n),
        .scl_s(lines_s[1]), .sda_s(lines_s[0]),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .wake_pulse(wake_pulse), .rd_data(rd_data),
        .sda_pull(sda_pull), .wake_req(wake_req),
        .wr_data(wr_data), .wr_strobe(wr_strobe), .rd_strobe(rd_strobe)
    );
endmodule

// File: tb/twowire_wake_slave_tb.sv
// Bench: a bus-master model over open-drain SDA, a vector table of single
// transfers, then directed wake, chaining, repeated-start and stop cases.
module twowire_wake_slave_tb_top;
    localparam int Q  = 16;   // core cycles per quarter bus bit
    localparam int NV = 7;

    // {is_read, address byte, data byte, expect address ack}
    localparam logic [17:0] VECS [NV] = '{
        {1'b0, 8'hA2, 8'h5A, 1'b1},
        {1'b0, 8'hA2, 8'hC3, 1'b1},
        {1'b0, 8'hA4, 8'h11, 1'b0},
        {1'b1, 8'hA3, 8'h96, 1'b1},
        {1'b0, 8'h22, 8'hFF, 1'b0},
        {1'b1, 8'hA3, 8'h01, 1'b1},
        {1'b1, 8'hB3, 8'h00, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic wake_pulse = 1'b0;
    logic [7:0] rd_data = 8'h00;
    logic sda_pull, wake_req, wr_strobe, rd_strobe;
    logic [7:0] wr_data;
    logic sda_line;

    int total = 0, bad = 0;
    int wr_cnt = 0, rd_cnt = 0, wk_cnt = 0;
    logic [7:0] wr_last = 8'h00;
    logic done = 1'b0;
    logic chain_mode = 1'b0;

    always #2 clk = ~clk;
    assign sda_line = sda_m & ~sda_pull;

    twowire_wake_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_pull(sda_pull), .wake_pulse(wake_pulse), .wake_req(wake_req),
        .wr_data(wr_data), .wr_strobe(wr_strobe),
        .rd_data(rd_data), .rd_strobe(rd_strobe)
    );

    // observe port strobes away from the active edge
    always @(negedge clk) begin
        if (wr_strobe) begin wr_cnt++; wr_last = wr_data; end
        if (rd_strobe) begin rd_cnt++; if (chain_mode) rd_data = rd_data + 8'h35; end
        if (wake_req)  wk_cnt++;
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n = 1);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wq(); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = ~sda_line; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic get_byte(input logic host_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl_m = 1'b1; wq(); b[i] = sda_line; wq(); scl_m = 1'b0; wq();
        end
        put_bit(~host_ack);
        sda_m = 1'b1;
    endtask

    // watchdog
    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] got;
        int w0, r0, k0;
        logic hi;

        // R10 reset state
        repeat (5) @(negedge clk);
        chk(!sda_pull && !wr_strobe && !rd_strobe && !wake_req, "R10 in reset", sda_pull, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(!sda_pull && !wr_strobe && !rd_strobe && !wake_req, "R10 after reset", sda_pull, 0);

        // vector table: R1 R2 R3 R4
        for (int v = 0; v < NV; v++) begin
            w0 = wr_cnt; r0 = rd_cnt;
            if (VECS[v][17]) rd_data = VECS[v][8:1];
            bus_start();
            send_byte(VECS[v][16:9], ack);
            chk(ack == VECS[v][0], "R1/R2 address ack", ack, VECS[v][0]);
            if (!VECS[v][0]) begin
                send_byte(VECS[v][8:1], ack);
                chk(!ack && wr_cnt == w0 && rd_cnt == r0, "R2 ignored after mismatch", wr_cnt - w0, 0);
            end else if (VECS[v][17]) begin
                get_byte(1'b0, got);
                chk(got == VECS[v][8:1] && rd_cnt == r0 + 1, "R4 read byte", got, VECS[v][8:1]);
            end else begin
                send_byte(VECS[v][8:1], ack);
                chk(ack && wr_cnt == w0 + 1 && wr_last == VECS[v][8:1], "R3 write byte", wr_last, VECS[v][8:1]);
            end
            bus_stop();
        end

        // R7 one wake request per start
        k0 = wk_cnt;
        bus_start();
        chk(wk_cnt == k0 + 1, "R7 wake_req per start", wk_cnt - k0, 1);
        bus_stop();

        // R6 first address after wake refused, retry accepted
        @(negedge clk); wake_pulse = 1'b1; @(negedge clk); wake_pulse = 1'b0;
        w0 = wr_cnt;
        bus_start();
        send_byte(8'hA2, ack);
        chk(!ack, "R6 post-wake address refused", ack, 0);
        send_byte(8'h77, ack);
        chk(wr_cnt == w0, "R6 refused transfer stores nothing", wr_cnt - w0, 0);
        bus_stop();
        bus_start();
        send_byte(8'hA2, ack);
        chk(ack, "R6 retry acknowledged", ack, 1);
        send_byte(8'h6B, ack);
        chk(ack && wr_last == 8'h6B, "R6 retry data", wr_last, 8'h6B);
        bus_stop();

        // R3 multi-byte write in order
        w0 = wr_cnt;
        bus_start();
        send_byte(8'hA2, ack);
        send_byte(8'h11, ack); chk(ack && wr_last == 8'h11, "R3 burst byte 0", wr_last, 8'h11);
        send_byte(8'h80, ack); chk(ack && wr_last == 8'h80, "R3 burst byte 1", wr_last, 8'h80);
        send_byte(8'h01, ack); chk(ack && wr_last == 8'h01, "R3 burst byte 2", wr_last, 8'h01);
        chk(wr_cnt == w0 + 3, "R3 burst strobe count", wr_cnt - w0, 3);
        bus_stop();

        // R5 chained read: host ACKs twice then NACKs
        chain_mode = 1'b1;
        rd_data = 8'hE7;
        r0 = rd_cnt;
        bus_start();
        send_byte(8'hA3, ack);
        get_byte(1'b1, got); chk(got == 8'hE7, "R5 chained read 0", got, 8'hE7);
        get_byte(1'b1, got); chk(got == 8'h1C, "R5 chained read 1", got, 8'h1C);
        get_byte(1'b0, got); chk(got == 8'h51, "R5 chained read 2", got, 8'h51);
        chk(rd_cnt == r0 + 3, "R5 fetch count", rd_cnt - r0, 3);
        // after NACK the line must stay released through more clocks
        hi = 1'b1;
        for (int i = 0; i < 4; i++) begin
            wq(); scl_m = 1'b1; wq(); hi = hi & sda_line; wq(); scl_m = 1'b0; wq();
        end
        chk(hi && rd_cnt == r0 + 3, "R5 released after host NACK", hi, 1);
        bus_stop();
        chain_mode = 1'b0;

        // R8 repeated start: write, then read from a new address phase
        bus_start();
        send_byte(8'hA2, ack);
        send_byte(8'h3C, ack);
        chk(ack && wr_last == 8'h3C, "R8 write before restart", wr_last, 8'h3C);
        rd_data = 8'h81;
        bus_start();
        send_byte(8'hA3, ack);
        chk(ack, "R8 address after repeated start", ack, 1);
        get_byte(1'b0, got);
        chk(got == 8'h81, "R8 read after repeated start", got, 8'h81);
        bus_stop();

        // R8 repeated start recovers from an ignored transfer
        bus_start();
        send_byte(8'hA4, ack);
        bus_start();
        send_byte(8'hA2, ack);
        chk(ack, "R8 restart after mismatch", ack, 1);
        bus_stop();

        // R9 clocks after a stop without a start do nothing
        w0 = wr_cnt;
        hi = 1'b1;
        scl_m = 1'b0; wq();
        for (int i = 7; i >= 0; i--) put_bit(8'hA2 >> i);
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); hi = sda_line; wq(); scl_m = 1'b0; wq();
        chk(hi && wr_cnt == w0, "R9 idle after stop", hi, 1);
        scl_m = 1'b1; wq();

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule